// File: doc/BRIEF.md
# Add/Subtract Unit with Condition Flags

This block adds or subtracts two operands of a parameterized width (8 bits by default). It returns the wrapped result and four condition flags: negative, zero, signed overflow and carry. The same datapath serves signed and unsigned operands. The caller chooses which error flag matters. Carry marks a wrong answer for unsigned operands. Overflow marks a wrong answer for two's-complement operands.

Subtraction computes X minus M. It is done by feeding the inverted M and a carry-in of one into a single ripple chain. On subtract the carry flag is the inverted chain carry-out, so in both operations it reads as "the unsigned answer wrapped". On subtract that makes it a borrow.

Overflow is the carry entering the top bit XORed with the carry leaving it. The result and the four flags are combinational. An optional hold stage captures the flag set on a clock edge when a load enable is high.

Top module: `arith_flag_unit`

## Requirements
- R1: With op_sub low, result equals (x_in + m_in) modulo 2^WIDTH.
- R2: With op_sub high, result equals (x_in - m_in) modulo 2^WIDTH.
- R3: On an add, flag_c is high exactly when the unsigned sum exceeds 2^WIDTH-1 (for example 224+64 gives 32 with flag_c high, and 96+64 gives 160 with it low).
- R4: On a subtract, flag_c is high exactly when m_in is greater than x_in as unsigned values (32-64 gives 224 with flag_c high, and 160-64 gives 96 with it low).
- R5: On an add, flag_v is high exactly when both operands have the same sign bit and the result's sign bit differs from it (96+64 sets it, and -32+64 does not).
- R6: On a subtract, flag_v is high exactly when the operand sign bits differ and the result's sign bit differs from that of x_in (-96-64 gives 96 with it set, and 32-64 gives -32 with it clear).
- R7: flag_n equals the result's most significant bit, and flag_z is high only when every result bit is zero.
- R8: While rst_n is low, held_flags reads 4'b0000, whatever flag_load does. Its bit order is [3]=N, [2]=Z, [1]=V, [0]=C.
- R9: On a rising clk edge with flag_load high, held_flags takes the current {N,Z,V,C}. With flag_load low it keeps its value, whatever the operands do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the flag hold stage |
| rst_n | input | 1 | Active-low asynchronous reset of the hold stage |
| op_sub | input | 1 | 0 selects add, 1 selects subtract (x_in - m_in) |
| x_in | input | WIDTH | First operand |
| m_in | input | WIDTH | Second operand |
| flag_load | input | 1 | Capture enable for held_flags |
| result | output | WIDTH | Wrapped sum or difference |
| flag_n | output | 1 | Negative: result MSB |
| flag_z | output | 1 | Zero result |
| flag_v | output | 1 | Signed overflow |
| flag_c | output | 1 | Unsigned carry on add, borrow on subtract |
| held_flags | output | 4 | Registered {N,Z,V,C} |

## Verification
The worked values from the requirements are applied first, one at a time. They separate a correct borrow sense from an uninverted carry-out on subtract. The signed examples show that overflow and carry move independently.

Boundary operands come next:
- 0 and all-ones;
- the signed extremes 127/128;
- -128 plus -128, which sets carry, overflow and zero together;
- 0-1 and 128-1.

These expose a stuck or swapped flag and a wrong carry-in. A long pseudo-random run follows, with random operation and load enable, and checks every flag and the held register against an integer model. This shows whether load-enable gating and capture timing are right.

// File: rtl/arith_flag_pkg.sv
package arith_flag_pkg;

   typedef struct packed {
      logic n;
      logic z;
      logic v;
      logic c;
   } flag_set_t;

   localparam int FLAG_COUNT = $bits(flag_set_t);

endpackage

// File: rtl/af_ripple_chain.sv
module af_ripple_chain #(
   parameter int WIDTH = 8
) (
   input  logic [WIDTH-1:0] a_in,
   input  logic [WIDTH-1:0] b_in,
   input  logic             c_in,
   output logic [WIDTH-1:0] sum_out,
   output logic             c_into_msb,
   output logic             c_out
);
   localparam int TOP = WIDTH - 1;

   logic [WIDTH:0] chain;

   assign chain[0] = c_in;

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      logic gen_t, prop_t;
      assign gen_t      = a_in[i] & b_in[i];
      assign prop_t     = a_in[i] ^ b_in[i];
      assign sum_out[i] = prop_t ^ chain[i];
      assign chain[i+1] = gen_t | (prop_t & chain[i]);
   end

   assign c_into_msb = chain[TOP];
   assign c_out      = chain[WIDTH];

endmodule

// File: rtl/af_flag_gen.sv
module af_flag_gen
   import arith_flag_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic [WIDTH-1:0] sum_in,
   input  logic             c_into_msb,
   input  logic             c_out,
   input  logic             is_sub,
   output flag_set_t        flags
);
   localparam int MSB = WIDTH - 1;

   always_comb begin
      flags.n = sum_in[MSB];
      flags.z = ~|sum_in;
      flags.v = c_into_msb ^ c_out;
      flags.c = c_out ^ is_sub;
   end

endmodule

// File: rtl/af_flag_hold.sv
module af_flag_hold
   import arith_flag_pkg::*;
#(
   parameter bit REGISTERED = 1'b1
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      load,
   input  flag_set_t flags_in,
   output flag_set_t flags_out
);
   if (REGISTERED) begin : g_reg
      flag_set_t held_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)    held_q <= '0;
         else if (load) held_q <= flags_in;
      end

      assign flags_out = held_q;

      // R9: no load keeps the stored flags
      a_r9_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
         !load |=> $stable(flags_out));
      // R9: load captures the flags present at the edge
      a_r9_hold_capture: assert property (@(posedge clk) disable iff (!rst_n)
         load |=> flags_out == $past(flags_in));
   end else begin : g_pass
      assign flags_out = flags_in;
   end

endmodule

// File: rtl/arith_flag_unit.sv
module arith_flag_unit
   import arith_flag_pkg::*;
#(
   parameter int WIDTH      = 8,
   parameter bit REG_FLAGS  = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             op_sub,
   input  logic [WIDTH-1:0] x_in,
   input  logic [WIDTH-1:0] m_in,
   input  logic             flag_load,
   output logic [WIDTH-1:0] result,
   output logic             flag_n,
   output logic             flag_z,
   output logic             flag_v,
   output logic             flag_c,
   output logic [3:0]       held_flags
);
   localparam int MSB = WIDTH - 1;

   if (WIDTH < 2) begin : g_bad_width
      $error("arith_flag_unit: WIDTH must be at least 2");
   end
   if (FLAG_COUNT != 4) begin : g_bad_flags
      $error("arith_flag_unit: flag set must hold four bits");
   end

   logic [WIDTH-1:0] b_eff;
   logic [WIDTH-1:0] sum_w;
   logic             c_msb_w, c_out_w;
   flag_set_t        flags_w, held_w;

   assign b_eff = op_sub ? ~m_in : m_in;

   af_ripple_chain #(.WIDTH(WIDTH)) u_chain (
      .a_in      (x_in),
      .b_in      (b_eff),
      .c_in      (op_sub),
      .sum_out   (sum_w),
      .c_into_msb(c_msb_w),
      .c_out     (c_out_w)
   );

   af_flag_gen #(.WIDTH(WIDTH)) u_flags (
      .sum_in    (sum_w),
      .c_into_msb(c_msb_w),
      .c_out     (c_out_w),
      .is_sub    (op_sub),
      .flags     (flags_w)
   );

   af_flag_hold #(.REGISTERED(REG_FLAGS)) u_hold (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (flag_load),
      .flags_in (flags_w),
      .flags_out(held_w)
   );

   assign result     = sum_w;
   assign flag_n     = flags_w.n;
   assign flag_z     = flags_w.z;
   assign flag_v     = flags_w.v;
   assign flag_c     = flags_w.c;
   assign held_flags = held_w;

   // R1: add result against a wide sum
   a_r1_add_result: assert property (@(posedge clk) disable iff (!rst_n)
      !op_sub |-> result == WIDTH'({1'b0, x_in} + {1'b0, m_in}));
   // R2: subtract result against a native difference
   a_r2_sub_result: assert property (@(posedge clk) disable iff (!rst_n)
      op_sub |-> result == WIDTH'(x_in - m_in));
   // R3: carry set only when the unsigned add wraps
   a_r3_add_carry: assert property (@(posedge clk) disable iff (!rst_n)
      !op_sub |-> flag_c == (({1'b0, x_in} + {1'b0, m_in}) > {1'b0, {WIDTH{1'b1}}}));
   // R4: borrow set only when M exceeds X
   a_r4_sub_borrow: assert property (@(posedge clk) disable iff (!rst_n)
      op_sub |-> flag_c == (m_in > x_in));
   // R5: add overflow from operand and result signs
   a_r5_add_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      !op_sub |-> flag_v == ((x_in[MSB] == m_in[MSB]) && (result[MSB] != x_in[MSB])));
   // R6: subtract overflow from operand and result signs
   a_r6_sub_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      op_sub |-> flag_v == ((x_in[MSB] != m_in[MSB]) && (result[MSB] != x_in[MSB])));

endmodule

// File: tb/arith_flag_unit_tb.sv
`timescale 1ns/1ps
module arith_flag_unit_tb;
   localparam int W = 8;

   typedef struct {
      logic         sub;
      logic [W-1:0] res;
      logic         n, z, v, c;
      logic [3:0]   held;
   } exp_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic op_sub = 1'b0;
   logic [W-1:0] x_in = '0, m_in = '0;
   logic flag_load = 1'b0;
   logic [W-1:0] result;
   logic flag_n, flag_z, flag_v, flag_c;
   logic [3:0] held_flags;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   exp_t exp_q[$];
   logic [3:0] model_held = 4'b0000;
   logic [3:0] prev_flags = 4'b0000;
   logic       prev_load  = 1'b0;

   always #2.5 clk = ~clk;

   arith_flag_unit #(.WIDTH(W), .REG_FLAGS(1'b1)) u_dut (
      .clk(clk), .rst_n(rst_n), .op_sub(op_sub), .x_in(x_in), .m_in(m_in),
      .flag_load(flag_load), .result(result), .flag_n(flag_n), .flag_z(flag_z),
      .flag_v(flag_v), .flag_c(flag_c), .held_flags(held_flags)
   );

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic exp_t model(input logic sub, input logic [W-1:0] x, input logic [W-1:0] m);
      exp_t e;
      int ua, ub, us, sa, sb, ss;
      ua = int'(x); ub = int'(m);
      sa = x[W-1] ? ua - 256 : ua;
      sb = m[W-1] ? ub - 256 : ub;
      if (sub) begin
         us = ua - ub; ss = sa - sb; e.c = (ua < ub);
      end else begin
         us = ua + ub; ss = sa + sb; e.c = (us > 255);
      end
      e.sub = sub;
      e.res = W'((us + 512) % 256);
      e.v   = (ss > 127) || (ss < -128);
      e.n   = e.res[W-1];
      e.z   = (e.res == '0);
      e.held = 4'b0000;
      return e;
   endfunction

   task automatic drive(input logic sub, input logic [W-1:0] x, input logic [W-1:0] m, input logic ld);
      exp_t e;
      @(posedge clk);
      if (prev_load) model_held = prev_flags;
      #1;
      op_sub = sub; x_in = x; m_in = m; flag_load = ld;
      e = model(sub, x, m);
      e.held = model_held;
      prev_flags = {e.n, e.z, e.v, e.c};
      prev_load  = ld;
      exp_q.push_back(e);
   endtask

   // monitor: compares at the falling edge
   initial begin
      forever begin
         @(negedge clk);
         if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            check(e.sub ? "R2 result" : "R1 result", int'(result), int'(e.res));
            check(e.sub ? "R4 borrow" : "R3 carry", int'(flag_c), int'(e.c));
            check(e.sub ? "R6 overflow" : "R5 overflow", int'(flag_v), int'(e.v));
            check("R7 negative", int'(flag_n), int'(e.n));
            check("R7 zero", int'(flag_z), int'(e.z));
            check("R9 held", int'(held_flags), int'(e.held));
         end
      end
   end

   initial begin
      #1_000_000;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      logic [15:0] lf;
      // R8: reset state with load asserted
      op_sub = 1'b0; x_in = 8'd224; m_in = 8'd64; flag_load = 1'b1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R8 reset held", int'(held_flags), 0);
      flag_load = 1'b0;
      @(negedge clk);
      check("R8 reset held", int'(held_flags), 0);
      rst_n = 1'b1;

      // worked values
      drive(1'b0, 8'd96,  8'd64, 1'b0);   // R1 R3 R5: 160, C=0, V=1
      drive(1'b0, 8'd224, 8'd64, 1'b0);   // R3: 32, C=1
      drive(1'b1, 8'd160, 8'd64, 1'b0);   // R4: 96, C=0
      drive(1'b1, 8'd32,  8'd64, 1'b1);   // R4 R6: 224, C=1, V=0
      drive(1'b0, 8'd224, 8'd64, 1'b0);   // R5 -32+64: V=0; R9 load captured
      drive(1'b1, 8'd160, 8'd64, 1'b0);   // R6 -96-64: 96, V=1; R9 held unchanged
      // boundaries
      drive(1'b0, 8'd0,   8'd0,   1'b1);  // R7 zero
      drive(1'b0, 8'd255, 8'd1,   1'b0);  // R3 wrap to zero
      drive(1'b0, 8'd127, 8'd1,   1'b1);  // R5 127+1
      drive(1'b0, 8'd128, 8'd128, 1'b1);  // R3 R5 R7 C,V,Z together
      drive(1'b1, 8'd0,   8'd0,   1'b0);  // R4 no borrow
      drive(1'b1, 8'd0,   8'd1,   1'b1);  // R4 borrow, 255
      drive(1'b1, 8'd128, 8'd1,   1'b0);  // R6 -128-1
      drive(1'b1, 8'd127, 8'd255, 1'b1);  // R6 127-(-1)
      drive(1'b1, 8'd55,  8'd55,  1'b0);  // R7 zero on subtract

      lf = 16'hACE1;
      for (int i = 0; i < 400; i++) begin
         lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
         lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
         drive(lf[0], lf[15:8] ^ W'(i), lf[7:0], lf[3] & lf[9]);
      end

      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule